// File: doc/BRIEF.md
# Configuration Command and Status Register Pair

This block holds the 16-bit command word and the 16-bit device status word that together fill the configuration dword at offset 04h of a bridge function that acts both as bus target and as bus master. Software reaches both words through one configuration access port. That port has a dword select, four byte enables, a write strobe, a read strobe, and 32-bit write and read data. The command word is in the low half of the dword and the status word is in the high half.

Only one command bit can be written: the special-cycle enable. The block drives this bit out to the bus logic, which uses it to decide whether shutdown and stop-grant special cycles are recognised. The I/O space, memory space and bus master enables cannot be turned off, so they always read as 1. Every other command bit reads as 0.

The status word keeps three sticky abort flags, each set by a one-cycle pulse from the bus interface. Software clears a flag by writing 1 to it. The rest of the status word is fixed at its reset pattern.

Top module: `cmdstat_regs`

## Requirements
- R1: After synchronous reset, a selected read returns dword 0280_0007h, and `special_cyc_en` is 0.
- R2: Dword bits 2:0 (I/O space, memory space and bus master enables) always read as 1, whatever is written.
- R3: Dword bit 3 is the special-cycle enable. A selected write with byte enable 0 set loads it from write data bit 3, and `special_cyc_en` follows the stored value from the next cycle on.
- R4: Dword bits 15:4 always read as 0.
- R5: A pulse on `evt_mabort`, `evt_tabort_rcvd` or `evt_tabort_sig` sets dword bit 29, 28 or 27 respectively, and the bit is visible from the next cycle.
- R6: A set abort flag stays set until a selected write with byte enable 3 set carries a 1 in that flag's bit. A 0 in that bit leaves the flag unchanged.
- R7: If an abort event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A write has no effect on a byte lane whose byte enable is 0. A write also has no effect when `cfg_sel` is low.
- R9: Dword bits 31:30, 26:16 always read as the status pattern 0280h, which has bits 25 and 23 at 1 and all the others at 0.
- R10: `cfg_rdata` is all zeros unless both `cfg_sel` and `cfg_rd` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Selects the dword at offset 04h |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Read data: status in 31:16, command in 15:0 |
| evt_mabort | input | 1 | Master-abort generated by this function |
| evt_tabort_rcvd | input | 1 | Target-abort received while acting as master |
| evt_tabort_sig | input | 1 | Target-abort signalled on an access to this function |
| special_cyc_en | output | 1 | Special-cycle recognition enable |

## Verification
The bench steps through every combination of select, write strobe, all sixteen byte-enable values and all eight abort-event combinations. Each combination is tried with all-zero write data, all-one write data and a mixed pattern. All-zero data shows whether a 0 write wrongly clears a flag. All-one data shows whether a hardwired or reserved bit can be written, and whether the wrong byte lane clears a flag. Because the events are driven at the same time as the writes, the same sweep also exercises set-versus-clear collisions, the special-cycle enable loading from lane 0 only, and the all-zero read data when the read is not selected.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
    localparam int DW          = 32;
    localparam int HW          = 16;
    localparam int NFLAG       = 3;
    localparam int SCE_BIT     = 3;
    localparam int FLAG_LSB    = 11;
    localparam logic [HW-1:0] CMD_FIXED  = 16'h0007;
    localparam logic [HW-1:0] STAT_FIXED = 16'h0280;

    // index 0: signalled target-abort, 1: received target-abort, 2: master-abort
    typedef logic [NFLAG-1:0] abort_vec_t;

    typedef struct packed {
        logic          sel;
        logic          wr;
        logic [3:0]    be;
        logic [DW-1:0] wdata;
    } cfg_wr_t;

    function automatic logic lane_write(input cfg_wr_t w, input int lane);
        return w.sel && w.wr && w.be[lane];
    endfunction
endpackage

// File: rtl/cmdstat_cmd.sv
module cmdstat_cmd
    import cmdstat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_wr_t       wreq,
    output logic [HW-1:0] cmd_word,
    output logic          sce
);
    logic sce_q;
    logic load;

    assign load = lane_write(wreq, 0);

    always_ff @(posedge clk) begin
        if (rst)       sce_q <= 1'b0;
        else if (load) sce_q <= wreq.wdata[SCE_BIT];
    end

    always_comb begin
        cmd_word          = CMD_FIXED;
        cmd_word[SCE_BIT] = sce_q;
    end

    assign sce = sce_q;

    assert_sce_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wreq.sel && wreq.wr && wreq.be[0]) |=> $stable(sce_q));
    assert_sce_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wreq.sel && wreq.wr && wreq.be[0]) |=> (sce_q == $past(wreq.wdata[SCE_BIT])));
endmodule

// File: rtl/cmdstat_status.sv
module cmdstat_status
    import cmdstat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_wr_t       wreq,
    input  abort_vec_t    evt,
    output logic [HW-1:0] stat_word
);
    abort_vec_t flag_q;
    logic       clr_lane;

    assign clr_lane = lane_write(wreq, 3);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic clr;
        assign clr = clr_lane && wreq.wdata[HW + FLAG_LSB + i];

        always_ff @(posedge clk) begin
            if (rst)         flag_q[i] <= 1'b0;
            else if (evt[i]) flag_q[i] <= 1'b1;
            else if (clr)    flag_q[i] <= 1'b0;
        end

        assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flag_q[i]);
        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr) |=> flag_q[i]);
        assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
            (!flag_q[i] && !evt[i]) |=> !flag_q[i]);
    end

    always_comb begin
        stat_word = STAT_FIXED;
        stat_word[FLAG_LSB +: NFLAG] = flag_q;
    end
endmodule

// File: rtl/cmdstat_regs.sv
module cmdstat_regs
    import cmdstat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_sel,
    input  logic [3:0]    cfg_be,
    input  logic [31:0]   cfg_wdata,
    input  logic          cfg_wr,
    input  logic          cfg_rd,
    output logic [31:0]   cfg_rdata,
    input  logic          evt_mabort,
    input  logic          evt_tabort_rcvd,
    input  logic          evt_tabort_sig,
    output logic          special_cyc_en
);
    cfg_wr_t       wreq;
    abort_vec_t    evt;
    logic [HW-1:0] cmd_word;
    logic [HW-1:0] stat_word;

    assign wreq = '{sel: cfg_sel, wr: cfg_wr, be: cfg_be, wdata: cfg_wdata};
    assign evt  = {evt_mabort, evt_tabort_rcvd, evt_tabort_sig};

    cmdstat_cmd u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wreq     (wreq),
        .cmd_word (cmd_word),
        .sce      (special_cyc_en)
    );

    cmdstat_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wreq      (wreq),
        .evt       (evt),
        .stat_word (stat_word)
    );

    assign cfg_rdata = (cfg_sel && cfg_rd) ? {stat_word, cmd_word} : '0;

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && cfg_rd) |-> (cfg_rdata == 32'h0));
    assert_hardwired_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_rd) |-> (cfg_rdata[2:0] == 3'b111));
    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_rd) |-> (cfg_rdata[15:4] == 12'h0));
    assert_sce_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_rd) |-> (cfg_rdata[3] == special_cyc_en));
endmodule

// File: tb/cmdstat_regs_tb.sv
module cmdstat_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_sel, cfg_wr, cfg_rd;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        evt_mabort, evt_tabort_rcvd, evt_tabort_sig;
    logic        special_cyc_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic       m_sce;
    logic [2:0] m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdstat_regs u_dut (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .evt_mabort(evt_mabort),
        .evt_tabort_rcvd(evt_tabort_rcvd), .evt_tabort_sig(evt_tabort_sig),
        .special_cyc_en(special_cyc_en)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_dword();
        return {16'h0280 | ({13'd0, m_flag} << 11), 16'h0007 | ({15'd0, m_sce} << 3)};
    endfunction

    task automatic idle();
        cfg_sel = 0; cfg_wr = 0; cfg_rd = 0; cfg_be = 0; cfg_wdata = 0;
        evt_mabort = 0; evt_tabort_rcvd = 0; evt_tabort_sig = 0;
    endtask

    task automatic readback(input string req);
        idle();
        cfg_sel = 1; cfg_rd = 1;
        #1;
        chk({req, " cmd"}, {16'h0, cfg_rdata[15:0]}, {16'h0, exp_dword() & 32'h0000_FFFF});
        chk({req, " stat"}, {16'h0, cfg_rdata[31:16]}, {16'h0, exp_dword() >> 16});
        chk({req, " sce_out"}, {31'h0, special_cyc_en}, {31'h0, m_sce});
    endtask

    task automatic step(input logic s, input logic w, input logic [3:0] be,
                        input logic [31:0] d, input logic [2:0] ev);
        @(negedge clk);
        idle();
        cfg_sel = s; cfg_wr = w; cfg_be = be; cfg_wdata = d;
        {evt_mabort, evt_tabort_rcvd, evt_tabort_sig} = ev;
        #1;
        if (!s) chk("R10 unselected read", cfg_rdata, 32'h0);
        @(posedge clk);
        if (s && w && be[0]) m_sce = d[3];
        for (int i = 0; i < 3; i++)
            m_flag[i] = ev[i] | (m_flag[i] & ~(s && w && be[3] && d[27+i]));
        @(negedge clk);
        readback("R2 R3 R4 R5 R6 R7 R8 R9 sweep");
    endtask

    initial begin
        idle();
        rst = 1;
        m_sce = 0; m_flag = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        readback("R1 reset");
        chk("R1 reset dword", cfg_rdata, 32'h0280_0007);

        cfg_rd = 1; cfg_sel = 0; #1;
        chk("R10 rd without sel", cfg_rdata, 32'h0);
        cfg_rd = 0; cfg_sel = 1; #1;
        chk("R10 sel without rd", cfg_rdata, 32'h0);

        step(1, 1, 4'hF, 32'hFFFF_FFFF, 3'b000);
        chk("R3 sce set", {31'h0, special_cyc_en}, 32'h1);
        step(1, 1, 4'hE, 32'h0000_0000, 3'b000);
        chk("R8 lane0 off keeps sce", {31'h0, special_cyc_en}, 32'h1);

        step(1, 0, 4'h0, 32'h0, 3'b111);
        step(1, 1, 4'hF, 32'hFFFF_FFFF, 3'b010);
        chk("R7 set wins", cfg_rdata & 32'h3800_0000, 32'h1000_0000);

        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
                for (int be = 0; be < 16; be++)
                    for (int ev = 0; ev < 8; ev++)
                        for (int p = 0; p < 3; p++)
                            step(s[0], w[0], be[3:0],
                                 (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF
                                                             : (32'h9E37_79B9 * (be + ev * 16 + 1)),
                                 ev[2:0]);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule